// File: doc/BRIEF.md
# Instruction Fetch Stage with Branch Redirect

This block is the front stage of a five-stage, word-addressed 32-bit pipeline. It owns the program counter and presents the counter's low bits to an instruction memory that answers in the same cycle. On each clock edge it captures the returned word, together with the address of the following instruction, into the buffer between fetch and decode. Fetch assumes that branches are not taken. It keeps stepping by one word until the execute stage reports a taken skip, jump or jump-and-link, and then it loads the target that execute supplies.

Hazard logic drives two controls. A stall freezes the counter and the buffer. A flush replaces the buffered word with a no-operation on the next clock edge. The block never clears state asynchronously to cancel an instruction; a multiplexer in front of the buffer selects the no-operation word instead. Once decode reports a halt, fetch parks on its current address and feeds only no-operations to decode. A later redirect resumes fetching. Cancelling the younger instruction in the decode/execute buffer is the job of the next stage.

Top module: `fetch_stage`

## Requirements
- R1: While reset is active, and until it is released, the memory address is 0 and the buffered instruction and buffered next-address are both 0.
- R2: With no redirect, stall, flush or halt, the PC advances by 1 per cycle, and the buffer captures the memory word for the current PC together with PC+1.
- R3: The memory address is the low 16 bits of the 32-bit PC, so a PC of 0x0001_FFFF presents 0xFFFF and the next PC presents 0x0000, while the buffered next-address keeps all 32 bits.
- R4: When a redirect is valid, the PC loads the redirect target and the buffer loads a no-operation with a next-address of 0.
- R5: A redirect in the same cycle as a stall still loads the target and a no-operation.
- R6: While stall is high and there is no redirect or flush, the PC, the buffered instruction and the buffered next-address keep their values.
- R7: Flush without a redirect loads a no-operation into the buffer. The PC still advances by 1 unless stall or halt holds it.
- R8: After halt is seen without a redirect, the PC stops advancing and the buffer receives only no-operations. This lasts until a redirect.
- R9: If halt and a redirect arrive in the same cycle, the redirect wins and fetch does not halt.
- R10: The no-operation word is 32'h0000_0000, which is the add opcode 0000 with all register fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_rdata | input | 32 | Instruction word for the presented address |
| redir_vld | input | 1 | Execute stage requests a change of flow |
| redir_tgt | input | 32 | New PC for a change of flow |
| stall | input | 1 | Hold PC and fetch/decode buffer |
| flush | input | 1 | Load a no-operation into the fetch/decode buffer |
| halt | input | 1 | Halt instruction seen in decode |
| imem_addr | output | 16 | Instruction memory word address |
| fd_instr | output | 32 | Buffered instruction to decode |
| fd_pc_inc | output | 32 | Buffered address of the next instruction |

## Verification
The bench builds the block with its default widths: a 32-bit PC in front of a 16-bit memory address. Because the PC is wider than the address, a redirect to just below a 64K boundary shows the address wrapping while the buffered next-address keeps counting. With a two-flop reset synchronizer, stall is held through reset release so that the reference model stays aligned. Stimulus then walks through every pairing of redirect, stall, flush and halt that decides priority.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  localparam int unsigned INSTR_W = 32;

  // Cancelled slots carry add r0,r0,r0: every bit clear.
  localparam logic [INSTR_W-1:0] NOOP_WORD = '0;

  typedef enum logic [1:0] {
    SRC_SEQ   = 2'd0,
    SRC_HOLD  = 2'd1,
    SRC_REDIR = 2'd2
  } pc_src_e;

  typedef enum logic [1:0] {
    BUF_LOAD = 2'd0,
    BUF_HOLD = 2'd1,
    BUF_NOOP = 2'd2
  } buf_act_e;

endpackage

// File: rtl/fetch_rst_sync.sv
module fetch_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[LAST];

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic     redir_vld,
  input  logic     stall,
  input  logic     flush,
  input  logic     halt,
  input  logic     halted_q,
  output pc_src_e  pc_src,
  output buf_act_e buf_act,
  output logic     halted_d
);

  logic halt_eff;

  assign halt_eff = halt | halted_q;

  // Priority: redirect, then stall, then halt; flush only picks the buffer input.
  always_comb begin
    pc_src   = SRC_SEQ;
    buf_act  = BUF_LOAD;
    halted_d = halted_q;
    if (redir_vld) begin
      pc_src   = SRC_REDIR;
      buf_act  = BUF_NOOP;
      halted_d = 1'b0;
    end else begin
      if (halt) halted_d = 1'b1;
      if (stall) begin
        pc_src  = SRC_HOLD;
        buf_act = flush ? BUF_NOOP : BUF_HOLD;
      end else begin
        pc_src  = halt_eff ? SRC_HOLD : SRC_SEQ;
        buf_act = (flush || halt_eff) ? BUF_NOOP : BUF_LOAD;
      end
    end
  end

endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
  import fetch_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pc_src_e         pc_src,
  input  logic [PC_W-1:0] redir_tgt,
  input  logic            halted_d,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] pc_inc,
  output logic            halted_q
);

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

  logic [PC_W-1:0] pc_d;
  logic            pc_en;

  assign pc_inc = pc_q + PC_STEP;

  always_comb begin
    pc_en = (pc_src != SRC_HOLD);
    pc_d  = (pc_src == SRC_REDIR) ? redir_tgt : pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted_q <= 1'b0;
    else        halted_q <= halted_d;
  end

endmodule

// File: rtl/fetch_fd_buf.sv
module fetch_fd_buf
  import fetch_pkg::*;
#(
  parameter int unsigned IW   = 32,
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  buf_act_e        buf_act,
  input  logic [IW-1:0]   instr_in,
  input  logic [PC_W-1:0] pc_inc_in,
  output logic [IW-1:0]   instr_q,
  output logic [PC_W-1:0] pc_inc_q
);

  localparam logic [IW-1:0] NOOP = IW'(NOOP_WORD);

  logic [IW-1:0]   instr_d;
  logic [PC_W-1:0] pc_inc_d;
  logic            buf_en;

  always_comb begin
    buf_en   = (buf_act != BUF_HOLD);
    instr_d  = instr_q;
    pc_inc_d = pc_inc_q;
    unique case (buf_act)
      BUF_LOAD: begin
        instr_d  = instr_in;
        pc_inc_d = pc_inc_in;
      end
      BUF_NOOP: begin
        instr_d  = NOOP;
        pc_inc_d = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q  <= NOOP;
      pc_inc_q <= '0;
    end else if (buf_en) begin
      instr_q  <= instr_d;
      pc_inc_q <= pc_inc_d;
    end
  end

endmodule

// File: rtl/fetch_stage.sv
module fetch_stage
  import fetch_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned IMEM_AW  = 16,
  parameter int unsigned IW       = INSTR_W,
  parameter int unsigned RST_SYNC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IW-1:0]      imem_rdata,
  input  logic               redir_vld,
  input  logic [PC_W-1:0]    redir_tgt,
  input  logic               stall,
  input  logic               flush,
  input  logic               halt,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [IW-1:0]      fd_instr,
  output logic [PC_W-1:0]    fd_pc_inc
);

  localparam logic [IW-1:0]      NOOP     = IW'(NOOP_WORD);
  localparam logic [IMEM_AW-1:0] ADDR_ONE = IMEM_AW'(1);

  logic            rst_sync_n;
  pc_src_e         pc_src;
  buf_act_e        buf_act;
  logic            halted_d;
  logic            halted_q;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_inc;

  fetch_rst_sync #(.STAGES(RST_SYNC)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fetch_ctrl u_ctrl (
    .redir_vld (redir_vld),
    .stall     (stall),
    .flush     (flush),
    .halt      (halt),
    .halted_q  (halted_q),
    .pc_src    (pc_src),
    .buf_act   (buf_act),
    .halted_d  (halted_d)
  );

  fetch_pc_reg #(.PC_W(PC_W)) u_pc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pc_src    (pc_src),
    .redir_tgt (redir_tgt),
    .halted_d  (halted_d),
    .pc_q      (pc_q),
    .pc_inc    (pc_inc),
    .halted_q  (halted_q)
  );

  fetch_fd_buf #(.IW(IW), .PC_W(PC_W)) u_fd_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .buf_act   (buf_act),
    .instr_in  (imem_rdata),
    .pc_inc_in (pc_inc),
    .instr_q   (fd_instr),
    .pc_inc_q  (fd_pc_inc)
  );

  assign imem_addr = pc_q[IMEM_AW-1:0];

  // R4
  redir_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redir_vld |=> (imem_addr == $past(redir_tgt[IMEM_AW-1:0]) && fd_instr == NOOP));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stall && !redir_vld && !flush) |=>
      ($stable(imem_addr) && $stable(fd_instr) && $stable(fd_pc_inc)));

  // R7
  flush_noop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> (fd_instr == NOOP && fd_pc_inc == '0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!redir_vld && !stall && !halt && !halted_q) |=>
      (imem_addr == $past(imem_addr) + ADDR_ONE));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt && !redir_vld) |=> $stable(imem_addr));

  // R9
  halt_redir_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt && redir_vld) |=> !halted_q);

endmodule

// File: tb/fetch_stage_bench.sv
`timescale 1ns/1ps
module fetch_stage_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_rdata;
  logic        redir_vld;
  logic [31:0] redir_tgt;
  logic        stall;
  logic        flush;
  logic        halt;
  logic [15:0] imem_addr;
  logic [31:0] fd_instr;
  logic [31:0] fd_pc_inc;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done     = 1'b0;
  bit    model_on = 1'b0;
  string cur_req  = "R1";

  // reference state
  logic [31:0] m_pc     = '0;
  logic [31:0] m_instr  = '0;
  logic [31:0] m_inc    = '0;
  bit          m_halted = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return {~a, a};
  endfunction

  assign imem_rdata = mem_word(imem_addr);

  fetch_stage u_fetch_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_rdata (imem_rdata),
    .redir_vld  (redir_vld),
    .redir_tgt  (redir_tgt),
    .stall      (stall),
    .flush      (flush),
    .halt       (halt),
    .imem_addr  (imem_addr),
    .fd_instr   (fd_instr),
    .fd_pc_inc  (fd_pc_inc)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference, advanced on each rising edge.
  always @(posedge clk) begin
    if (model_on) begin
      logic [31:0] fetched;
      bit hh;
      fetched = mem_word(m_pc[15:0]);
      if (redir_vld) begin
        m_pc = redir_tgt; m_instr = 32'h0; m_inc = 32'h0; m_halted = 1'b0;
      end else begin
        hh = halt || m_halted;
        if (stall) begin
          if (flush) begin m_instr = 32'h0; m_inc = 32'h0; end
        end else begin
          if (flush || hh) begin m_instr = 32'h0; m_inc = 32'h0; end
          else begin m_instr = fetched; m_inc = m_pc + 32'd1; end
          if (!hh) m_pc = m_pc + 32'd1;
        end
        if (halt) m_halted = 1'b1;
      end
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (model_on && !done) begin
      chk(cur_req, "imem_addr", {16'h0, imem_addr}, {16'h0, m_pc[15:0]});
      chk(cur_req, "fd_instr",  fd_instr,  m_instr);
      chk(cur_req, "fd_pc_inc", fd_pc_inc, m_inc);
    end
  end

  task automatic drive(input bit rv, input logic [31:0] tg, input bit st,
                       input bit fl, input bit ht);
    @(negedge clk);
    redir_vld = rv; redir_tgt = tg; stall = st; flush = fl; halt = ht;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; redir_vld = 1'b0; redir_tgt = '0;
    stall = 1'b1; flush = 1'b0; halt = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "imem_addr", {16'h0, imem_addr}, 32'h0);
    chk("R1", "fd_instr",  fd_instr,  32'h0);
    chk("R1", "fd_pc_inc", fd_pc_inc, 32'h0);
    rst_n = 1'b1; model_on = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "addr after release", {16'h0, imem_addr}, 32'h0);

    cur_req = "R2";
    idle(20);

    cur_req = "R6";
    for (int i = 0; i < 3; i++) drive(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    idle(2);
    drive(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    idle(2);

    cur_req = "R4";
    drive(1'b1, 32'h0000_0100, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R4", "addr at target", {16'h0, imem_addr}, 32'h0000_0100);
    chk("R4", "noop after redirect", fd_instr, 32'h0);
    idle(4);

    cur_req = "R5";
    drive(1'b1, 32'h0000_0200, 1'b1, 1'b0, 1'b0);
    idle(1);
    chk("R5", "addr at target", {16'h0, imem_addr}, 32'h0000_0200);
    idle(3);

    cur_req = "R3";
    drive(1'b1, 32'h0001_FFFF, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R3", "addr low half", {16'h0, imem_addr}, 32'h0000_FFFF);
    idle(1);
    chk("R3", "addr wraps", {16'h0, imem_addr}, 32'h0000_0000);
    chk("R3", "full next-address", fd_pc_inc, 32'h0002_0000);
    idle(3);

    cur_req = "R7";
    drive(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
    idle(1);
    // R10: cancelled slot is all zero
    chk("R10", "noop word", fd_instr, 32'h0000_0000);
    idle(2);
    drive(1'b0, 32'h0, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    idle(3);

    cur_req = "R8";
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
    idle(5);
    drive(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    idle(2);
    drive(1'b1, 32'h0000_0040, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R8", "resume after redirect", {16'h0, imem_addr}, 32'h0000_0040);
    idle(4);

    cur_req = "R9";
    drive(1'b1, 32'h0000_0080, 1'b0, 1'b0, 1'b1);
    idle(2);
    chk("R9", "not halted", {16'h0, imem_addr}, 32'h0000_0081);
    idle(3);

    cur_req = "R2";
    for (int i = 0; i < 30; i++)
      drive(1'b0, 32'h0, (i % 5) == 2, (i % 7) == 3, 1'b0);
    idle(3);

    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule